// File: doc/BRIEF.md
# Load Queue with Store-Order Violation Detection

This block keeps the loads that are in flight in a processor's memory pipeline, in program order. Each load is given a tag when it enters, carries the sequence number it was issued with, and later receives its effective address. When a store executes, the store's sequence number and address are presented to the block. The block then looks for a load that is younger than the store, already knows its address, and touches the same 256-byte region. Such a load has read memory before an older store wrote it. The oldest such load is recorded as the violator and a violation counter is incremented.

The recorded violator is offered on a valid/ready output. It stays there, unchanged, until the pipeline takes it; taking it clears the record. While a violator is held, further store checks do not search. Loads leave the queue in two ways. A commit bound retires loads from the oldest end. A squash bound removes loads from the youngest end after a pipeline flush. Each of these walks the queue one load per cycle, and every tag it frees goes back to a first-in first-out pool of free tags.

Loads enter on a valid/ready handshake. A source that finds `alloc_ready` low keeps its load and its sequence number presented until the load is accepted. On the violator output, the block holds `vio_tag` and `vio_seq` stable for as long as `vio_valid` is high and `vio_ready` is low. Sequence numbers are assumed to increase in program order and not to wrap while loads are held.

Top module: `ldq_order_check`

## Requirements
- R1: `alloc_ready` is high when the free-tag pool is not empty and no squash is pending. A load accepted with `alloc_valid` and `alloc_ready` joins the youngest end of the queue and takes the tag shown on `alloc_tag` in that same cycle. The pool holds 2*ENTRIES tags. After reset it hands out 0, 1, 2 and so on in order, and freed tags are handed out again in the order they were freed.
- R2: `addr_valid` with `addr_tag` writes the address of a held load and marks it known. A write to a tag that is not held is ignored. A load whose address is not known never matches a store check.
- R3: A store check compares only against loads whose sequence number is strictly greater than `st_seq`.
- R4: A load matches when bits AW-1 down to 8 of its address equal the same bits of `st_addr`.
- R5: One cycle after `st_valid`, `st_resp_valid` is high and `st_resp_hit` reports whether a match was found. If several loads match, the oldest one becomes the violator. `viol_count` goes up by one, wrapping, in the cycle the hit is reported.
- R6: While `vio_valid` is high, a store check performs no search. The response it gets has `st_resp_hit` = 0, and neither the count nor the violator changes.
- R7: A violator stays on `vio_valid`, `vio_tag` and `vio_seq` unchanged until the cycle `vio_ready` is high. In the next cycle `vio_valid` is low.
- R8: After `commit_valid` with `commit_seq`, loads are retired from the oldest end, one per cycle, starting in the next cycle. This continues while the oldest load's sequence number is at most the bound, and the tag of each retired load returns to the pool.
- R9: After `squash_valid` with `squash_seq`, loads are removed from the youngest end, one per cycle, starting in the next cycle. This continues while their sequence number is greater than the bound. A pending squash takes priority over commit and holds `alloc_ready` low.
- R10: If a squash removes the load held as violator, `vio_valid` goes low in the cycle after that removal.
- R11: After reset the queue is empty, `alloc_ready` is 1 with `alloc_tag` 0, `vio_valid` and `st_resp_valid` are 0, and `viol_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | A load is offered for entry |
| alloc_ready | output | 1 | Queue can accept a load |
| alloc_seq | input | SEQW | Sequence number of the offered load |
| alloc_tag | output | TAGW | Tag the accepted load receives |
| addr_valid | input | 1 | Address update strobe |
| addr_tag | input | TAGW | Tag of the load being updated |
| addr_value | input | AW | Effective address of that load |
| st_valid | input | 1 | Store check request |
| st_seq | input | SEQW | Sequence number of the executing store |
| st_addr | input | AW | Address of the executing store |
| st_resp_valid | output | 1 | Store check result is present |
| st_resp_hit | output | 1 | Store check found an ordering violation |
| commit_valid | input | 1 | New commit bound |
| commit_seq | input | SEQW | Youngest committed sequence number |
| squash_valid | input | 1 | New squash bound |
| squash_seq | input | SEQW | Loads younger than this are flushed |
| vio_valid | output | 1 | A violator is held |
| vio_ready | input | 1 | Consumer takes the violator |
| vio_tag | output | TAGW | Tag of the violating load |
| vio_seq | output | SEQW | Sequence number of the violating load |
| viol_count | output | CNTW | Number of violations found |

## Verification
`alloc_ready` and `alloc_tag` follow the block's state in the same cycle. A store check's response and the violator it records appear one rising edge after the request, and the count moves on that same edge. Commit and squash remove their first load on the edge after the bound arrives, then one load per edge. The bench advances its behavioural model once per rising edge, using exactly the inputs driven before that edge. It compares every output at the following falling edge, so each result is checked in the cycle it is due. Directed sequences also test the specific outcomes listed in R1 to R11: the oldest of several matches, skipping of older loads, the granule boundary, suppression while a violator is held, and the effects of commit, squash and a full queue.

// File: rtl/lq_pkg.sv
package lq_pkg;
  // Address bits below this position are ignored by the conflict compare.
  localparam int unsigned LQ_GRAN_SHIFT = 8;

  // Which end of the order ring loses an entry in a cycle.
  typedef enum logic [1:0] {
    RM_NONE = 2'd0,
    RM_HEAD = 2'd1,
    RM_TAIL = 2'd2
  } lq_rm_e;
endpackage

// File: rtl/lq_free_pool.sv
module lq_free_pool #(
  parameter int CAP  = 8,
  parameter int TAGW = 3,
  localparam int OCW = $clog2(CAP + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pop,
  output logic [TAGW-1:0] head_tag,
  output logic            nonempty,
  input  logic            push,
  input  logic [TAGW-1:0] push_tag
);
  logic [TAGW-1:0] slot_q [CAP];
  logic [TAGW-1:0] rd_q, wr_q;
  logic [OCW-1:0]  cnt_q;

  function automatic logic [TAGW-1:0] bump(input logic [TAGW-1:0] p);
    return (int'(p) == CAP - 1) ? '0 : p + 1'b1;
  endfunction

  assign head_tag = slot_q[rd_q];
  assign nonempty = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CAP; i++) slot_q[i] <= TAGW'(i);
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= OCW'(CAP);
    end else begin
      if (pop) rd_q <= bump(rd_q);
      if (push) begin
        slot_q[wr_q] <= push_tag;
        wr_q         <= bump(wr_q);
      end
      if (push && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_POOL_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt_q != '0); // R1
  AST_POOL_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> int'(cnt_q) < CAP); // R8
endmodule

// File: rtl/lq_order_ring.sv
module lq_order_ring #(
  parameter int CAP  = 8,
  parameter int TAGW = 3,
  localparam int OCW = $clog2(CAP + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [TAGW-1:0] push_tag,
  input  lq_pkg::lq_rm_e  rm,
  output logic [TAGW-1:0] head_tag,
  output logic [TAGW-1:0] tail_tag,
  output logic [OCW-1:0]  occ,
  output logic [TAGW-1:0] ord_tag [CAP]
);
  import lq_pkg::*;

  logic [TAGW-1:0] ring_q [CAP];
  logic [TAGW-1:0] hd_q, tl_q;   // tl_q is the next free position
  logic [OCW-1:0]  occ_q;

  function automatic logic [TAGW-1:0] inc(input logic [TAGW-1:0] p);
    return (int'(p) == CAP - 1) ? '0 : p + 1'b1;
  endfunction
  function automatic logic [TAGW-1:0] dec(input logic [TAGW-1:0] p);
    return (p == '0) ? TAGW'(CAP - 1) : p - 1'b1;
  endfunction

  assign occ      = occ_q;
  assign head_tag = ring_q[hd_q];
  assign tail_tag = ring_q[dec(tl_q)];

  always_comb begin
    for (int i = 0; i < CAP; i++) begin
      int s;
      s = int'(hd_q) + i;
      if (s >= CAP) s = s - CAP;
      ord_tag[i] = ring_q[s];
    end
  end

  logic pop_any;
  assign pop_any = (rm != RM_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CAP; i++) ring_q[i] <= '0;
      hd_q  <= '0;
      tl_q  <= '0;
      occ_q <= '0;
    end else begin
      if (rm == RM_HEAD) hd_q <= inc(hd_q);
      if (rm == RM_TAIL) tl_q <= dec(tl_q);
      else if (push) begin
        ring_q[tl_q] <= push_tag;
        tl_q         <= inc(tl_q);
      end
      if (push && !pop_any)      occ_q <= occ_q + 1'b1;
      else if (pop_any && !push) occ_q <= occ_q - 1'b1;
    end
  end

  AST_RING_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop_any) |-> int'(occ_q) < CAP); // R1
  AST_RING_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop_any |-> occ_q != '0); // R8
  AST_RING_TAIL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (rm == RM_TAIL) |-> !push); // R9
endmodule

// File: rtl/lq_conflict_search.sv
module lq_conflict_search #(
  parameter int CAP  = 8,
  parameter int TAGW = 3,
  parameter int SEQW = 16,
  parameter int AW   = 32,
  localparam int OCW = $clog2(CAP + 1)
) (
  input  logic            en,
  input  logic [TAGW-1:0] ord_tag [CAP],
  input  logic [OCW-1:0]  occ,
  input  logic            skip_first,
  input  logic            skip_last,
  input  logic [SEQW-1:0] seq_arr [CAP],
  input  logic [AW-1:0]   addr_arr [CAP],
  input  logic [CAP-1:0]  known,
  input  logic [SEQW-1:0] st_seq,
  input  logic [AW-1:0]   st_addr,
  output logic            hit,
  output logic [TAGW-1:0] hit_tag
);
  import lq_pkg::*;

  // Walk from the oldest position so the first match is the oldest one.
  always_comb begin
    hit     = 1'b0;
    hit_tag = '0;
    for (int i = 0; i < CAP; i++) begin
      logic [TAGW-1:0] t;
      logic            cand;
      t    = ord_tag[i];
      cand = en && !hit && (i < int'(occ))
             && !(skip_first && i == 0)
             && !(skip_last && i == int'(occ) - 1);
      if (cand && known[t] && (seq_arr[t] > st_seq)
          && (addr_arr[t][AW-1:LQ_GRAN_SHIFT] == st_addr[AW-1:LQ_GRAN_SHIFT])) begin
        hit     = 1'b1;
        hit_tag = t;
      end
    end
  end
endmodule

// File: rtl/ldq_order_check.sv
module ldq_order_check #(
  parameter int ENTRIES = 4,
  parameter int SEQW    = 16,
  parameter int AW      = 32,
  parameter int CNTW    = 16,
  localparam int CAP    = 2 * ENTRIES,
  localparam int TAGW   = $clog2(CAP),
  localparam int OCW    = $clog2(CAP + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_valid,
  output logic            alloc_ready,
  input  logic [SEQW-1:0] alloc_seq,
  output logic [TAGW-1:0] alloc_tag,
  input  logic            addr_valid,
  input  logic [TAGW-1:0] addr_tag,
  input  logic [AW-1:0]   addr_value,
  input  logic            st_valid,
  input  logic [SEQW-1:0] st_seq,
  input  logic [AW-1:0]   st_addr,
  output logic            st_resp_valid,
  output logic            st_resp_hit,
  input  logic            commit_valid,
  input  logic [SEQW-1:0] commit_seq,
  input  logic            squash_valid,
  input  logic [SEQW-1:0] squash_seq,
  output logic            vio_valid,
  input  logic            vio_ready,
  output logic [TAGW-1:0] vio_tag,
  output logic [SEQW-1:0] vio_seq,
  output logic [CNTW-1:0] viol_count
);
  import lq_pkg::*;

  // Per-tag load state.
  logic [SEQW-1:0] seq_q  [CAP];
  logic [AW-1:0]   addr_q [CAP];
  logic [CAP-1:0]  known_q, live_q;

  // Pending walk bounds.
  logic            sq_pend_q, cm_pend_q;
  logic [SEQW-1:0] sq_bound_q, cm_bound_q;

  logic            vio_v_q, resp_v_q, resp_hit_q;
  logic [TAGW-1:0] vio_tag_q;
  logic [SEQW-1:0] vio_seq_q;
  logic [CNTW-1:0] cnt_q;

  logic [TAGW-1:0] head_tag, tail_tag, pool_head;
  logic [TAGW-1:0] ord_tag [CAP];
  logic [OCW-1:0]  occ;
  logic            pool_nonempty;

  logic            sq_act, cm_act, alloc_fire, rel;
  logic [TAGW-1:0] rel_tag;
  lq_rm_e          rm;
  logic            srch_en, srch_hit;
  logic [TAGW-1:0] srch_tag;

  assign sq_act     = sq_pend_q && (occ != '0) && (seq_q[tail_tag] > sq_bound_q);
  assign cm_act     = !sq_pend_q && cm_pend_q && (occ != '0) && (seq_q[head_tag] <= cm_bound_q);
  assign rm         = sq_act ? RM_TAIL : (cm_act ? RM_HEAD : RM_NONE);
  assign rel        = sq_act || cm_act;
  assign rel_tag    = sq_act ? tail_tag : head_tag;
  assign alloc_ready = !sq_pend_q && pool_nonempty;
  assign alloc_tag  = pool_head;
  assign alloc_fire = alloc_valid && alloc_ready;
  assign srch_en    = st_valid && !vio_v_q;

  lq_free_pool #(.CAP(CAP), .TAGW(TAGW)) u_pool (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop      (alloc_fire),
    .head_tag (pool_head),
    .nonempty (pool_nonempty),
    .push     (rel),
    .push_tag (rel_tag)
  );

  lq_order_ring #(.CAP(CAP), .TAGW(TAGW)) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (alloc_fire),
    .push_tag (pool_head),
    .rm       (rm),
    .head_tag (head_tag),
    .tail_tag (tail_tag),
    .occ      (occ),
    .ord_tag  (ord_tag)
  );

  lq_conflict_search #(.CAP(CAP), .TAGW(TAGW), .SEQW(SEQW), .AW(AW)) u_search (
    .en         (srch_en),
    .ord_tag    (ord_tag),
    .occ        (occ),
    .skip_first (cm_act),
    .skip_last  (sq_act),
    .seq_arr    (seq_q),
    .addr_arr   (addr_q),
    .known      (known_q),
    .st_seq     (st_seq),
    .st_addr    (st_addr),
    .hit        (srch_hit),
    .hit_tag    (srch_tag)
  );

  // Entry state: removal wins over a same-cycle address write.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < CAP; t++) begin
        seq_q[t]  <= '0;
        addr_q[t] <= '0;
      end
      known_q <= '0;
      live_q  <= '0;
    end else begin
      for (int t = 0; t < CAP; t++) begin
        if (rel && rel_tag == TAGW'(t)) begin
          live_q[t]  <= 1'b0;
          known_q[t] <= 1'b0;
        end else if (alloc_fire && pool_head == TAGW'(t)) begin
          live_q[t]  <= 1'b1;
          known_q[t] <= 1'b0;
          seq_q[t]   <= alloc_seq;
        end else if (addr_valid && addr_tag == TAGW'(t) && live_q[t]) begin
          known_q[t] <= 1'b1;
          addr_q[t]  <= addr_value;
        end
      end
    end
  end

  // Commit and squash walk bounds.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sq_pend_q  <= 1'b0;
      cm_pend_q  <= 1'b0;
      sq_bound_q <= '0;
      cm_bound_q <= '0;
    end else begin
      if (squash_valid) begin
        sq_pend_q  <= 1'b1;
        sq_bound_q <= squash_seq;
      end else if (sq_pend_q && !sq_act) begin
        sq_pend_q <= 1'b0;
      end
      if (commit_valid) begin
        cm_pend_q  <= 1'b1;
        cm_bound_q <= commit_seq;
      end else if (!sq_pend_q && cm_pend_q && !cm_act) begin
        cm_pend_q <= 1'b0;
      end
    end
  end

  // Store check response, violator record and count.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_v_q   <= 1'b0;
      resp_hit_q <= 1'b0;
      vio_v_q    <= 1'b0;
      vio_tag_q  <= '0;
      vio_seq_q  <= '0;
      cnt_q      <= '0;
    end else begin
      resp_v_q   <= st_valid;
      resp_hit_q <= srch_hit;
      if (srch_hit) begin
        vio_v_q   <= 1'b1;
        vio_tag_q <= srch_tag;
        vio_seq_q <= seq_q[srch_tag];
        cnt_q     <= cnt_q + 1'b1;
      end else if (vio_v_q && (vio_ready || (sq_act && tail_tag == vio_tag_q))) begin
        vio_v_q <= 1'b0;
      end
    end
  end

  assign st_resp_valid = resp_v_q;
  assign st_resp_hit   = resp_hit_q;
  assign vio_valid     = vio_v_q;
  assign vio_tag       = vio_tag_q;
  assign vio_seq       = vio_seq_q;
  assign viol_count    = cnt_q;

  AST_ALLOC_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |-> int'(occ) < CAP); // R1
  AST_HIT_IS_YOUNGER: assert property (@(posedge clk) disable iff (!rst_n)
    srch_hit |-> (seq_q[srch_tag] > st_seq) && known_q[srch_tag]); // R3
  AST_HIT_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_resp_valid && st_resp_hit) |-> viol_count == CNTW'($past(viol_count) + 1'b1)); // R5
  AST_HELD_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && vio_valid) |=> !st_resp_hit); // R6
  AST_VIO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (vio_valid && !vio_ready && !sq_act) |=> vio_valid && $stable(vio_tag) && $stable(vio_seq)); // R7
  AST_SQUASH_HOLDS_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |=> !alloc_ready); // R9
endmodule

// File: tb/ldq_order_check_bench.sv
`timescale 1ns/1ps
module ldq_order_check_bench;
  localparam int ENTRIES = 4;
  localparam int SEQW    = 16;
  localparam int AW      = 32;
  localparam int CNTW    = 16;
  localparam int CAP     = 2 * ENTRIES;
  localparam int TAGW    = $clog2(CAP);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 0, addr_valid = 0, st_valid = 0, commit_valid = 0, squash_valid = 0, vio_ready = 0;
  logic [SEQW-1:0] alloc_seq = '0, st_seq = '0, commit_seq = '0, squash_seq = '0;
  logic [TAGW-1:0] addr_tag = '0;
  logic [AW-1:0]   addr_value = '0, st_addr = '0;
  logic alloc_ready, st_resp_valid, st_resp_hit, vio_valid;
  logic [TAGW-1:0] alloc_tag, vio_tag;
  logic [SEQW-1:0] vio_seq;
  logic [CNTW-1:0] viol_count;

  always #4 clk = ~clk;

  ldq_order_check #(.ENTRIES(ENTRIES), .SEQW(SEQW), .AW(AW), .CNTW(CNTW)) u_ldq_order_check (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_seq(alloc_seq), .alloc_tag(alloc_tag),
    .addr_valid(addr_valid), .addr_tag(addr_tag), .addr_value(addr_value),
    .st_valid(st_valid), .st_seq(st_seq), .st_addr(st_addr),
    .st_resp_valid(st_resp_valid), .st_resp_hit(st_resp_hit),
    .commit_valid(commit_valid), .commit_seq(commit_seq),
    .squash_valid(squash_valid), .squash_seq(squash_seq),
    .vio_valid(vio_valid), .vio_ready(vio_ready), .vio_tag(vio_tag), .vio_seq(vio_seq),
    .viol_count(viol_count)
  );

  int nchk = 0, nfail = 0;
  bit finished = 0;

  // Behavioural reference state.
  int ord[$];
  int pool[$];
  int mseq [CAP];
  int maddr[CAP];
  bit mknown[CAP];
  bit mlive[CAP];
  bit m_sq_pend, m_cm_pend, m_vio_v, m_resp_v, m_resp_hit;
  int m_sq_b, m_cm_b, m_vio_tag, m_vio_seq, m_cnt;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    ord.delete();
    pool.delete();
    for (int i = 0; i < CAP; i++) begin
      pool.push_back(i);
      mseq[i] = 0; maddr[i] = 0; mknown[i] = 0; mlive[i] = 0;
    end
    m_sq_pend = 0; m_cm_pend = 0; m_vio_v = 0; m_resp_v = 0; m_resp_hit = 0;
    m_sq_b = 0; m_cm_b = 0; m_vio_tag = 0; m_vio_seq = 0; m_cnt = 0;
  endtask

  function automatic bit m_ready();
    return !m_sq_pend && pool.size() > 0;
  endfunction

  task automatic model_next();
    int n;
    bit sa, ca, fire, found, osq;
    int ftag, t;
    n    = ord.size();
    osq  = m_sq_pend;
    sa   = m_sq_pend && n > 0 && mseq[ord[n-1]] > m_sq_b;
    ca   = !m_sq_pend && m_cm_pend && n > 0 && mseq[ord[0]] <= m_cm_b;
    fire = alloc_valid && m_ready();
    found = 0; ftag = 0;
    if (st_valid && !m_vio_v) begin
      for (int i = 0; i < n; i++) begin
        if (ca && i == 0) continue;
        if (sa && i == n - 1) continue;
        t = ord[i];
        if (mknown[t] && mseq[t] > int'(st_seq) && (maddr[t] >> 8) == (int'(st_addr) >> 8)) begin
          found = 1; ftag = t; break;
        end
      end
    end
    m_resp_v = st_valid;
    m_resp_hit = found;
    if (found) begin
      m_vio_v = 1; m_vio_tag = ftag; m_vio_seq = mseq[ftag]; m_cnt = (m_cnt + 1) % 65536;
    end else if (m_vio_v && (vio_ready || (sa && ord[n-1] == m_vio_tag))) begin
      m_vio_v = 0;
    end
    if (addr_valid && mlive[addr_tag] &&
        !(sa && int'(addr_tag) == ord[n-1]) && !(ca && int'(addr_tag) == ord[0])) begin
      mknown[addr_tag] = 1; maddr[addr_tag] = int'(addr_value);
    end
    if (fire) t = pool.pop_front();
    if (sa) begin
      int r; r = ord.pop_back(); pool.push_back(r); mlive[r] = 0; mknown[r] = 0;
    end
    if (ca) begin
      int r; r = ord.pop_front(); pool.push_back(r); mlive[r] = 0; mknown[r] = 0;
    end
    if (fire) begin
      ord.push_back(t); mseq[t] = int'(alloc_seq); mknown[t] = 0; mlive[t] = 1;
    end
    if (squash_valid) begin m_sq_pend = 1; m_sq_b = int'(squash_seq); end
    else if (m_sq_pend && !sa) m_sq_pend = 0;
    if (commit_valid) begin m_cm_pend = 1; m_cm_b = int'(commit_seq); end
    else if (!osq && m_cm_pend && !ca) m_cm_pend = 0;
  endtask

  task automatic compare_all();
    chk("R1", "alloc_ready", alloc_ready, m_ready());
    if (m_ready()) chk("R1", "alloc_tag", alloc_tag, pool[0]);
    chk("R5", "st_resp_valid", st_resp_valid, m_resp_v);
    chk("R5", "st_resp_hit", st_resp_hit, m_resp_hit);
    chk("R5", "viol_count", viol_count, m_cnt);
    chk("R7", "vio_valid", vio_valid, m_vio_v);
    if (m_vio_v) begin
      chk("R7", "vio_tag", vio_tag, m_vio_tag);
      chk("R7", "vio_seq", vio_seq, m_vio_seq);
    end
  endtask

  task automatic idle_inputs();
    alloc_valid = 0; addr_valid = 0; st_valid = 0; commit_valid = 0; squash_valid = 0; vio_ready = 0;
  endtask

  task automatic step();
    model_next();
    @(negedge clk);
    compare_all();
    idle_inputs();
  endtask

  task automatic do_alloc(input int s);
    alloc_valid = 1; alloc_seq = SEQW'(s); step();
  endtask
  task automatic do_addr(input int t, input int a);
    addr_valid = 1; addr_tag = TAGW'(t); addr_value = AW'(a); step();
  endtask
  task automatic do_store(input int s, input int a);
    st_valid = 1; st_seq = SEQW'(s); st_addr = AW'(a); step();
  endtask
  task automatic do_read();
    vio_ready = 1; step();
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11", "alloc_ready", alloc_ready, 1);
    chk("R11", "alloc_tag", alloc_tag, 0);
    chk("R11", "vio_valid", vio_valid, 0);
    chk("R11", "st_resp_valid", st_resp_valid, 0);
    chk("R11", "viol_count", viol_count, 0);

    // R1 tags come out of the pool in order
    for (int i = 0; i < 4; i++) begin
      chk("R1", "alloc_tag order", alloc_tag, i);
      do_alloc(10 * (i + 1));
    end
    do_addr(0, 'h1200); do_addr(1, 'h1234); do_addr(2, 'h12FF); do_addr(3, 'h5600);

    // R5 oldest of two younger matches (seq 20 and 30)
    do_store(15, 'h1200);
    chk("R5", "hit", st_resp_hit, 1);
    chk("R5", "oldest vio_seq", vio_seq, 20);
    chk("R5", "vio_tag", vio_tag, 1);
    chk("R5", "count", viol_count, 1);
    // R6 held violator blocks the search
    do_store(25, 'h1280);
    chk("R6", "hit while held", st_resp_hit, 0);
    chk("R6", "vio_seq kept", vio_seq, 20);
    chk("R6", "count kept", viol_count, 1);
    // R7 read clears
    do_read();
    chk("R7", "cleared", vio_valid, 0);
    // R3 older load at seq 20 is skipped
    do_store(25, 'h1280);
    chk("R3", "hit", st_resp_hit, 1);
    chk("R3", "vio_seq", vio_seq, 30);
    do_read();
    // R4 granule compare
    do_store(5, 'h1300);
    chk("R4", "next granule no hit", st_resp_hit, 0);
    do_store(5, 'h56FF);
    chk("R4", "same granule hit", st_resp_hit, 1);
    chk("R4", "vio_seq", vio_seq, 40);
    do_read();
    // R2 unknown address never matches
    chk("R1", "alloc_tag", alloc_tag, 4);
    do_alloc(50);
    do_store(45, 'h0000);
    chk("R2", "unknown addr", st_resp_hit, 0);
    do_addr(4, 'h0010);
    do_store(45, 'h0000);
    chk("R2", "known addr", st_resp_hit, 1);
    chk("R2", "vio_seq", vio_seq, 50);
    do_read();
    // R8 commit retires 10 and 20
    commit_valid = 1; commit_seq = 25; step();
    idle(3);
    do_store(0, 'h1234);
    chk("R8", "first match after commit", vio_seq, 30);
    do_read();
    // R9 squash removes 50 and 40
    squash_valid = 1; squash_seq = 35; step();
    chk("R9", "alloc blocked", alloc_ready, 0);
    idle(3);
    chk("R9", "alloc back", alloc_ready, 1);
    do_store(0, 'h5600);
    chk("R9", "squashed load gone", st_resp_hit, 0);
    chk("R1", "tag reuse order", alloc_tag, 5);
    // R10 squash of the violator
    do_alloc(60);
    do_addr(5, 'h7700);
    do_store(55, 'h7700);
    chk("R10", "violator set", vio_valid, 1);
    squash_valid = 1; squash_seq = 55; step();
    idle(1);
    chk("R10", "violator dropped", vio_valid, 0);
    idle(2);
    // R1 full queue
    for (int i = 0; i < 7; i++) do_alloc(70 + 10 * i);
    chk("R1", "full", alloc_ready, 0);
    commit_valid = 1; commit_seq = 1000; step();
    idle(9);
    chk("R8", "drained", alloc_ready, 1);
    do_store(0, 'h12FF);
    chk("R8", "retired load gone", st_resp_hit, 0);

    // Mixed traffic against the model
    begin
      int nseq;
      nseq = 200;
      for (int c = 0; c < 3000; c++) begin
        if ($urandom_range(1, 0) == 1) begin
          alloc_valid = 1; alloc_seq = SEQW'(nseq);
          if (m_ready()) nseq = nseq + 1 + $urandom_range(2, 0);
        end
        if ($urandom_range(1, 0) == 1) begin
          addr_valid = 1; addr_tag = TAGW'($urandom_range(CAP - 1, 0));
          addr_value = AW'('h1000 + $urandom_range('h3FF, 0));
        end
        if ($urandom_range(2, 0) == 0) begin
          st_valid = 1; st_seq = SEQW'(nseq - $urandom_range(20, 0));
          st_addr = AW'('h1000 + $urandom_range('h3FF, 0));
        end
        if ($urandom_range(15, 0) == 0) begin
          commit_valid = 1; commit_seq = SEQW'(nseq - $urandom_range(15, 0));
        end
        if ($urandom_range(23, 0) == 0) begin
          squash_valid = 1; squash_seq = SEQW'(nseq - $urandom_range(10, 0));
        end
        vio_ready = ($urandom_range(2, 0) == 0);
        step();
      end
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule